// File: doc/BRIEF.md
# Cycle-Steal DMA Channel Arbiter

This block decides which of several DMA channels owns a shared external bus for its next single transfer, when every channel runs in auto-request cycle-steal mode. Each channel raises a level request for as long as it has work. The arbiter answers with a one-hot channel grant that is held for a whole transfer. The transfer engine, which is outside the block, ends each transfer with a one-cycle done strobe.

After every transfer the arbiter gives up the bus for exactly one slot. If another bus master is requesting at the moment the transfer ends, that master gets the slot as a one-cycle grant. If no other master is requesting, the bus stays idle for that cycle. The channel selection for the next transfer is made only at this boundary. A running transfer is never cut short: a higher-priority channel that arrives during it waits for the boundary, and a lower-priority arrival waits behind it.

Top module: `cs_dma_arb`

## Requirements
- R1: While reset is active and in the first cycle after it, no channel grant or foreign grant is asserted and `bus_idle` is 1.
- R2: When no transfer or release slot is in progress, a channel request seen at a clock edge produces that channel's grant from that same edge, with no release slot before it.
- R3: When several channels request at once, the grant goes to the lowest-numbered requesting channel. Bit k of `ch_req` and `ch_gnt` belongs to channel k, and channel 0 has the highest priority.
- R4: A channel grant stays unchanged until `xfer_done` is seen. A request from a channel of higher or lower priority during a transfer does not change it.
- R5: The edge that samples `xfer_done` during a transfer removes the channel grant, so every transfer is followed by a release slot one cycle long.
- R6: If `ext_req` is 1 at the edge that ends a transfer, `ext_gnt` is 1 for exactly the release slot and 0 afterwards.
- R7: If `ext_req` is 0 at the edge that ends a transfer, the release slot has no grant of any kind and `bus_idle` is 1 for that one cycle.
- R8: At the end of a release slot, the highest-priority channel requesting at that moment is granted. If no channel is requesting, the block returns to the idle state.
- R9: At most one of the channel grants and `ext_gnt` is 1 at any time, and `bus_idle` is 1 exactly when none of them is 1.
- R10: `xfer_done` has no effect while no channel grant is active.
- R11: A channel that keeps its request asserted through a release slot is granted again after that slot, if no higher-priority channel is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | N_CH | Level request, bit k for channel k |
| ext_req | input | 1 | Bus request from a foreign bus master |
| xfer_done | input | 1 | One-cycle pulse in the last cycle of the current transfer |
| ch_gnt | output | N_CH | One-hot grant of the selected channel, held for the transfer |
| ext_gnt | output | 1 | One-cycle grant of the release slot to the foreign master |
| bus_idle | output | 1 | No grant of any kind is active |

## Verification
The bench builds the arbiter with its default four channels and models the transfer engine as a three-cycle bus cycle. With three cycles there is room to raise a higher-priority request, a lower-priority request and a foreign request in the middle of a running transfer. With four channels, three of them can be pending behind a fourth at the same time, so the order of service at successive release slots is exercised.

// File: rtl/cs_dma_arb.sv
module cs_dma_arb #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] ch_req,
  input  logic            ext_req,
  input  logic            xfer_done,
  output logic [N_CH-1:0] ch_gnt,
  output logic            ext_gnt,
  output logic            bus_idle
);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_REL} st_t;

  st_t             st;
  logic [N_CH-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (ch_req[i]) pick = N_CH'(1) << i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ch_gnt  <= '0;
      ext_gnt <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (|ch_req) begin
          ch_gnt <= pick;
          st     <= ST_XFER;
        end
        ST_XFER: if (xfer_done) begin
          ch_gnt  <= '0;
          ext_gnt <= ext_req;
          st      <= ST_REL;
        end
        default: begin
          ext_gnt <= 1'b0;
          ch_gnt  <= pick;
          st      <= (|ch_req) ? ST_XFER : ST_IDLE;
        end
      endcase
    end
  end

  assign bus_idle = ~(|ch_gnt) & ~ext_gnt;

endmodule

module cs_dma_arb_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] ch_req,
  input logic            ext_req,
  input logic            xfer_done,
  input logic [N_CH-1:0] ch_gnt,
  input logic            ext_gnt,
  input logic            bus_idle
);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_gnt, ext_gnt}));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle == (ch_gnt == '0 && !ext_gnt));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && !xfer_done) |=> $stable(ch_gnt));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && xfer_done) |=> (ch_gnt == '0));

  p_ext_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && xfer_done && ext_req) |=> ext_gnt);

  p_ext_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt |=> !ext_gnt);

  p_idle_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && xfer_done && !ext_req) |=> bus_idle);

  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_gnt != '0 && $past(ch_gnt) == '0) |->
      ((ch_gnt & $past(ch_req)) != '0 && ($past(ch_req) & (ch_gnt - 1'b1)) == '0));

endmodule

bind cs_dma_arb cs_dma_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ext_req(ext_req),
  .xfer_done(xfer_done), .ch_gnt(ch_gnt), .ext_gnt(ext_gnt), .bus_idle(bus_idle)
);

// File: tb/cs_dma_arb_tb.sv
module cs_dma_arb_tb_top;
  localparam int N_CH = 4;
  localparam int LEN  = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic ext_req = 0;
  logic xfer_done = 0;
  logic force_done = 0;
  logic [N_CH-1:0] ch_req, ch_gnt;
  logic ext_gnt, bus_idle;

  int req_cnt [N_CH];
  int n_tests = 0, n_fail = 0, cyc = 0, xcnt = 0;
  int m_st = 0, m_ch = -1, m_ext = 0;
  string m_tag = "R1";

  always #10 clk = ~clk;

  always_comb for (int k = 0; k < N_CH; k++) ch_req[k] = (req_cnt[k] != 0);

  cs_dma_arb #(.N_CH(N_CH)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ext_req(ext_req),
    .xfer_done(xfer_done), .ch_gnt(ch_gnt), .ext_gnt(ext_gnt), .bus_idle(bus_idle)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int first_req();
    for (int i = 0; i < N_CH; i++) if (ch_req[i]) return i;
    return -1;
  endfunction

  // reference model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_ch = -1; m_ext = 0; m_tag = "R1";
    end else begin
      case (m_st)
        0: if (ch_req != 0) begin m_ch = first_req(); m_st = 1; m_tag = "R2"; end
           else m_tag = "R10";
        1: if (xfer_done) begin
             m_ch = -1; m_ext = ext_req; m_st = 2;
             m_tag = ext_req ? "R6" : "R7";
           end else m_tag = "R4";
        default: begin
          m_ext = 0;
          if (ch_req != 0) begin m_ch = first_req(); m_st = 1; m_tag = "R8"; end
          else begin m_st = 0; m_tag = "R8"; end
        end
      endcase
    end
  end

  // transfer engine, request clearing and per-cycle comparison
  always @(negedge clk) begin
    int exp_g;
    exp_g = (m_ch < 0) ? 0 : (1 << m_ch);
    check(ch_gnt == N_CH'(exp_g), m_tag, ch_gnt, exp_g);
    check(ext_gnt == m_ext[0], (m_ext != 0) ? "R6" : "R5", ext_gnt, m_ext);
    check(bus_idle == (m_ch < 0 && m_ext == 0), "R9", bus_idle, (m_ch < 0 && m_ext == 0));
    if (ch_gnt != 0) begin
      xcnt++;
      xfer_done = (xcnt == LEN);
      if (xcnt == LEN)
        for (int k = 0; k < N_CH; k++)
          if (ch_gnt[k] && req_cnt[k] > 0) req_cnt[k]--;
    end else begin
      xcnt = 0;
      xfer_done = force_done;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin
    for (int k = 0; k < N_CH; k++) req_cnt[k] = 0;
    step(3);
    check(ch_gnt == 0 && !ext_gnt && bus_idle, "R1", {ch_gnt, ext_gnt, bus_idle}, 1);
    rst_n = 1;
    step(1);
    check(ch_gnt == 0 && bus_idle, "R1", ch_gnt, 0);

    // R10: stray done while idle
    force_done = 1;
    step(1);
    force_done = 0;
    step(2);
    check(ch_gnt == 0 && bus_idle, "R10", ch_gnt, 0);

    // R2 / R3: two channels from idle
    req_cnt[2] = 1; req_cnt[1] = 1;
    step(1);
    check(ch_gnt == 4'b0010, "R3", ch_gnt, 4'b0010);
    // R4: higher and foreign arrivals mid-transfer
    req_cnt[0] = 1; ext_req = 1;
    step(1);
    check(ch_gnt == 4'b0010, "R4", ch_gnt, 4'b0010);
    step(2);
    check(ext_gnt && ch_gnt == 0, "R6", {ch_gnt, ext_gnt}, 1);
    ext_req = 0;
    step(1);
    check(ch_gnt == 4'b0001, "R8", ch_gnt, 4'b0001);
    step(12);
    check(ch_gnt == 0 && bus_idle, "R8", ch_gnt, 0);

    // R11: channel 3 with two transfers back to back
    req_cnt[3] = 2;
    step(1);
    check(ch_gnt == 4'b1000, "R2", ch_gnt, 4'b1000);
    step(3);
    check(ch_gnt == 0 && bus_idle, "R7", ch_gnt, 0);
    step(1);
    check(ch_gnt == 4'b1000, "R11", ch_gnt, 4'b1000);
    step(6);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 3 * N_CH);
      if (k < N_CH && req_cnt[k] == 0) req_cnt[k] = $urandom_range(1, 3);
      ext_req = ($urandom_range(0, 2) == 0);
      step(1);
    end
    ext_req = 0;
    for (int k = 0; k < N_CH; k++) req_cnt[k] = 0;
    step(10);
    check(ch_gnt == 0 && bus_idle, "R8", ch_gnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule